// File: doc/BRIEF.md
# Trace Port Cycle Packer

The block takes one trace sample per clock from a processor trace port and packs consecutive samples into 32-bit words for a trace RAM. A sample carries a 3-bit pipeline status, a packet field, a sync flag and a trigger flag. The port width chosen at capture start sets the packet field width and the packing density. A 4-bit port gives three 8-bit slots per word. An 8-bit port gives two 12-bit slots. A 16-bit port gives one 20-bit slot. Inside a slot the status sits in the low three bits, the packet field above it, and the sync flag just above the packet. Slot 0 is the oldest sample and occupies the least significant slot.

A trigger is carried in-band. The status field holds the reserved code 3'b111, and the true status replaces the low three packet bits. The trace RAM needs no extra flag bit for this.

Control is a four-state machine:
- IDLE: drain complete, waiting.
- RUN: capturing samples.
- FLUSH: emitting a partly filled word.
- REJECT: the configuration is not supported.

The transitions are as follows:
- IDLE goes to RUN when capture is enabled with a supported configuration. The width is latched at this point.
- IDLE goes to REJECT when capture is enabled with an unsupported configuration.
- RUN goes to FLUSH when capture is disabled with a partial word held.
- RUN goes to IDLE when capture is disabled with no partial word held.
- FLUSH always goes to IDLE.
- REJECT goes to IDLE when capture is disabled.

Top module: `trace_cycle_packer`

## Requirements
- R1: After reset, word_valid is 0, drain_empty is 1 and cfg_err is 0.
- R2: With width_sel 2'b00 (4-bit port), each slot is 8 bits: status in [2:0], packet in [6:3], sync in [7]. The slots start at bits 0, 8 and 16, and three samples make one word.
- R3: With width_sel 2'b01 (8-bit port), each slot is 12 bits: status in [2:0], packet in [10:3], sync in [11]. The slots start at bits 0 and 12, and two samples make one word.
- R4: With width_sel 2'b10 (16-bit port), one sample makes one word: status in [2:0], packet in [18:3], sync in [19].
- R5: When smp_trig is 1, the slot status field is 3'b111 and packet bits [2:0] hold the sample's true status. The other packet bits are kept.
- R6: Word bits above the last slot are zero, and smp_pkt bits above the port width are dropped.
- R7: word_valid is high for the cycle after the clock edge that accepts the sample filling the last slot, carrying that word.
- R8: Disabling capture (cap_en low) with a partial word held emits that word with its empty slots zeroed. The word appears two edges after cap_en is seen low, and drain_empty rises with it. drain_empty is 0 while capture runs or drains.
- R9: Disabling capture with no partial word emits no word, and drain_empty returns to 1 on the next edge.
- R10: mode_sel 2'b10 (multiplexed) or 2'b11, demultiplexed mode (mode_sel 2'b01) with a width other than 8-bit, and width_sel 2'b11 are all rejected. cfg_err is 1 while cap_en stays high, and no word is produced. mode_sel 2'b00 with any valid width, and 2'b01 with the 8-bit width, are accepted.
- R11: Width and mode are latched when capture starts. Changing width_sel or mode_sel during a capture does not change the packing.
- R12: Samples with smp_valid low, and samples presented on the edge that starts capture, are not packed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_en | input | 1 | Capture enable |
| width_sel | input | 2 | Port width: 00 = 4-bit, 01 = 8-bit, 10 = 16-bit, 11 = invalid |
| mode_sel | input | 2 | Port mode: 00 = normal, 01 = demultiplexed, 10 = multiplexed, 11 = reserved |
| smp_valid | input | 1 | Sample present this cycle |
| smp_stat | input | 3 | Pipeline status of the sample |
| smp_pkt | input | 16 | Packet field; only the low port-width bits are used |
| smp_sync | input | 1 | Sync flag of the sample |
| smp_trig | input | 1 | Trigger flag of the sample |
| word_valid | output | 1 | Packed word strobe toward the trace RAM |
| word_data | output | 32 | Packed word |
| drain_empty | output | 1 | No capture running and no partial word held |
| cfg_err | output | 1 | Capture requested with an unsupported configuration |

## Verification
A wrong slot index or a stale latched width shows up as a misplaced slot in the next emitted word. This happens at most three samples after the fault. A state stuck in FLUSH or REJECT shows at once on drain_empty or cfg_err, on the edge after the faulty transition. A reference model in the bench compares valid, data and both flags on every clock, so any divergence is reported in the cycle it first reaches a port.

// File: rtl/tpk_pkg.sv
package tpk_pkg;

    localparam int STAT_W   = 3;
    localparam int PKT_MAX  = 16;
    localparam int WORD_W   = 32;
    localparam int SLOT_MAX = STAT_W + PKT_MAX + 1;
    localparam int IDX_W    = 2;
    localparam int SH_W     = 6;

    localparam logic [STAT_W-1:0] TRIG_CODE = '1;

    typedef enum logic [1:0] {
        PW4    = 2'b00,
        PW8    = 2'b01,
        PW16   = 2'b10,
        PW_BAD = 2'b11
    } port_w_e;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_DEMUX  = 2'b01,
        PM_MUX    = 2'b10,
        PM_RSVD   = 2'b11
    } port_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLUSH,
        ST_REJECT
    } pk_state_e;

    // packet field width in bits for a port width
    function automatic logic [4:0] pkt_bits(port_w_e w);
        unique case (w)
            PW8:     return 5'd8;
            PW16:    return 5'd16;
            default: return 5'd4;
        endcase
    endfunction

    // bits per packed slot
    function automatic logic [4:0] slot_bits(port_w_e w);
        return 5'(STAT_W + 1) + pkt_bits(w);
    endfunction

    // index of the final slot in a word
    function automatic logic [IDX_W-1:0] last_slot(port_w_e w);
        unique case (w)
            PW4:     return 2'd2;
            PW8:     return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic cfg_supported(port_w_e w, port_mode_e m);
        return (w != PW_BAD) &&
               ((m == PM_NORMAL) || ((m == PM_DEMUX) && (w == PW8)));
    endfunction

endpackage

// File: rtl/tpk_slot_fmt.sv
module tpk_slot_fmt
    import tpk_pkg::*;
(
    input  port_w_e                 width,
    input  logic [STAT_W-1:0]       stat,
    input  logic [PKT_MAX-1:0]      pkt,
    input  logic                    sync,
    input  logic                    trig,
    output logic [SLOT_MAX-1:0]     slot
);

    logic [4:0]          pw;
    logic [PKT_MAX-1:0]  keep_mask;
    logic [PKT_MAX-1:0]  pkt_m;
    logic [STAT_W-1:0]   stat_f;

    always_comb begin
        pw        = pkt_bits(width);
        keep_mask = PKT_MAX'((33'd1 << pw) - 33'd1);
        pkt_m     = pkt & keep_mask;
        stat_f    = stat;
        if (trig) begin
            // in-band trigger: reserved status, true status in packet low bits
            pkt_m[STAT_W-1:0] = stat;
            stat_f            = TRIG_CODE;
        end
        slot = SLOT_MAX'(stat_f)
             | (SLOT_MAX'(pkt_m) << STAT_W)
             | (SLOT_MAX'(sync)  << (5'(STAT_W) + pw));
    end

endmodule

// File: rtl/tpk_ctrl.sv
module tpk_ctrl
    import tpk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_en,
    input  logic       cfg_good,
    input  logic       partial,
    output pk_state_e  state,
    output logic       load_cfg,
    output logic       take,
    output logic       flush,
    output logic       drain_empty,
    output logic       cfg_err
);

    pk_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (cap_en)  nxt = cfg_good ? ST_RUN : ST_REJECT;
            ST_RUN:    if (!cap_en) nxt = partial ? ST_FLUSH : ST_IDLE;
            ST_FLUSH:  nxt = ST_IDLE;
            ST_REJECT: if (!cap_en) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load_cfg    = 1'b0;
        take        = 1'b0;
        flush       = 1'b0;
        drain_empty = 1'b0;
        cfg_err     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                drain_empty = 1'b1;
                load_cfg    = cap_en && cfg_good;
            end
            ST_RUN:    take    = cap_en;
            ST_FLUSH:  flush   = 1'b1;
            ST_REJECT: cfg_err = 1'b1;
            default:   drain_empty = 1'b0;
        endcase
    end

endmodule

// File: rtl/tpk_assembler.sv
module tpk_assembler
    import tpk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_cfg,
    input  port_w_e               width_in,
    input  logic                  take,
    input  logic                  smp_valid,
    input  logic                  flush,
    input  logic [SLOT_MAX-1:0]   slot,
    output port_w_e               lat_w,
    output logic [WORD_W-1:0]     word_data,
    output logic                  word_valid,
    output logic                  partial
);

    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] merged;
    logic [IDX_W-1:0]  idx;
    logic [SH_W-1:0]   shamt;

    always_comb begin
        shamt  = SH_W'(idx) * SH_W'(slot_bits(lat_w));
        merged = acc | (WORD_W'(slot) << shamt);
    end

    assign partial = (idx != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_w      <= PW4;
            acc        <= '0;
            idx        <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (load_cfg) begin
                lat_w <= width_in;
                acc   <= '0;
                idx   <= '0;
            end else if (flush) begin
                word_data  <= acc;
                word_valid <= 1'b1;
                acc        <= '0;
                idx        <= '0;
            end else if (take && smp_valid) begin
                if (idx == last_slot(lat_w)) begin
                    word_data  <= merged;
                    word_valid <= 1'b1;
                    acc        <= '0;
                    idx        <= '0;
                end else begin
                    acc <= merged;
                    idx <= idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/trace_cycle_packer.sv
module trace_cycle_packer
    import tpk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_en,
    input  logic [1:0]            width_sel,
    input  logic [1:0]            mode_sel,
    input  logic                  smp_valid,
    input  logic [STAT_W-1:0]     smp_stat,
    input  logic [PKT_MAX-1:0]    smp_pkt,
    input  logic                  smp_sync,
    input  logic                  smp_trig,
    output logic                  word_valid,
    output logic [WORD_W-1:0]     word_data,
    output logic                  drain_empty,
    output logic                  cfg_err
);

    pk_state_e             st;
    port_w_e               lat_w;
    logic                  load_cfg;
    logic                  take;
    logic                  flush;
    logic                  partial;
    logic                  cfg_good;
    logic [SLOT_MAX-1:0]   slot;

    assign cfg_good = cfg_supported(port_w_e'(width_sel), port_mode_e'(mode_sel));

    tpk_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en      (cap_en),
        .cfg_good    (cfg_good),
        .partial     (partial),
        .state       (st),
        .load_cfg    (load_cfg),
        .take        (take),
        .flush       (flush),
        .drain_empty (drain_empty),
        .cfg_err     (cfg_err)
    );

    tpk_slot_fmt u_fmt (
        .width (lat_w),
        .stat  (smp_stat),
        .pkt   (smp_pkt),
        .sync  (smp_sync),
        .trig  (smp_trig),
        .slot  (slot)
    );

    tpk_assembler u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_cfg   (load_cfg),
        .width_in   (port_w_e'(width_sel)),
        .take       (take),
        .smp_valid  (smp_valid),
        .flush      (flush),
        .slot       (slot),
        .lat_w      (lat_w),
        .word_data  (word_data),
        .word_valid (word_valid),
        .partial    (partial)
    );

endmodule

// File: rtl/tpk_checker.sv
module tpk_checker
    import tpk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic               word_valid,
    input  logic [WORD_W-1:0]  word_data,
    input  logic               drain_empty,
    input  logic               cfg_err,
    input  pk_state_e          state,
    input  port_w_e            lat_w
);

    // R10
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !word_valid);

    // R6
    top_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word_data[31:24] == 8'h00));

    // R6
    wide_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && lat_w == PW16) |-> (word_data[31:20] == 12'h000));

    // R8
    flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |=> (word_valid && drain_empty));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> $stable(lat_w));

    // R12
    word_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ($past(smp_valid) || $past(state) == ST_FLUSH));

endmodule

bind trace_cycle_packer tpk_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .word_valid  (word_valid),
    .word_data   (word_data),
    .drain_empty (drain_empty),
    .cfg_err     (cfg_err),
    .state       (st),
    .lat_w       (lat_w)
);

// File: tb/sim_trace_cycle_packer.sv
module sim_trace_cycle_packer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cap_en;
    logic [1:0]  width_sel;
    logic [1:0]  mode_sel;
    logic        smp_valid;
    logic [2:0]  smp_stat;
    logic [15:0] smp_pkt;
    logic        smp_sync;
    logic        smp_trig;
    logic        word_valid;
    logic [31:0] word_data;
    logic        drain_empty;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail   = 0;

    int          m_phase = 0;   // 0 idle, 1 capture, 2 draining, 3 refused
    int          m_w = 0;
    int unsigned m_q[$];
    bit          m_valid = 0;
    int unsigned m_word = 0;
    int unsigned last_word = 0;
    int          word_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_cycle_packer u0 (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .width_sel(width_sel),
        .mode_sel(mode_sel), .smp_valid(smp_valid), .smp_stat(smp_stat),
        .smp_pkt(smp_pkt), .smp_sync(smp_sync), .smp_trig(smp_trig),
        .word_valid(word_valid), .word_data(word_data),
        .drain_empty(drain_empty), .cfg_err(cfg_err)
    );

    function automatic int unsigned ref_slot(int w, int unsigned st, int unsigned pk,
                                             bit sy, bit tr);
        int pw = 4 << w;
        int unsigned p = pk & ((32'd1 << pw) - 1);
        int unsigned s = st;
        if (tr) begin
            p = (p & ~32'd7) | st;
            s = 7;
        end
        return s | (p << 3) | (int'(sy) << (3 + pw));
    endfunction

    function automatic int unsigned ref_pack(int w, int unsigned q[$]);
        int unsigned r = 0;
        foreach (q[i]) r = r | (q[i] << (i * ((4 << w) + 4)));
        return r;
    endfunction

    function automatic bit ref_ok(int w, int m);
        return (w != 3) && (m == 0 || (m == 1 && w == 1));
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        m_valid = 0;
        if (!rst_n) begin
            m_phase = 0;
            m_q.delete();
        end else begin
            case (m_phase)
                0: if (cap_en) begin
                       if (ref_ok(int'(width_sel), int'(mode_sel))) begin
                           m_phase = 1;
                           m_w = int'(width_sel);
                           m_q.delete();
                       end else m_phase = 3;
                   end
                1: if (!cap_en) m_phase = (m_q.size() > 0) ? 2 : 0;
                   else if (smp_valid) begin
                       m_q.push_back(ref_slot(m_w, smp_stat, smp_pkt, smp_sync, smp_trig));
                       if (m_q.size() == 3 - m_w) begin
                           m_word = ref_pack(m_w, m_q);
                           m_valid = 1;
                           m_q.delete();
                       end
                   end
                2: begin
                       m_word = ref_pack(m_w, m_q);
                       m_valid = 1;
                       m_q.delete();
                       m_phase = 0;
                   end
                default: if (!cap_en) m_phase = 0;
            endcase
        end
    end

    task automatic chk(string tag, bit ok, int unsigned act, int unsigned exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 word_valid", word_valid === m_valid, word_valid, m_valid);
            if (m_valid)
                chk(m_w == 0 ? "R2 word" : (m_w == 1 ? "R3 word" : "R4 word"),
                    word_data === m_word, word_data, m_word);
            chk("R8 drain_empty", drain_empty === (m_phase == 0), drain_empty, m_phase == 0);
            chk("R10 cfg_err", cfg_err === (m_phase == 3), cfg_err, m_phase == 3);
            if (word_valid) begin
                last_word = word_data;
                word_cnt++;
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic smp(int st, int pk, bit sy, bit tr);
        smp_valid = 1; smp_stat = 3'(st); smp_pkt = 16'(pk);
        smp_sync = sy; smp_trig = tr;
        tick();
        smp_valid = 0; smp_stat = 0; smp_pkt = 0; smp_sync = 0; smp_trig = 0;
    endtask

    task automatic gap(int n);
        smp_valid = 0; smp_stat = 3'd5; smp_pkt = 16'hABCD; smp_sync = 1; smp_trig = 1;
        tick(n);
        smp_stat = 0; smp_pkt = 0; smp_sync = 0; smp_trig = 0;
    endtask

    task automatic start(int w, int m);
        width_sel = 2'(w); mode_sel = 2'(m); cap_en = 1;
        tick();
    endtask

    task automatic stop();
        cap_en = 0;
        tick(3);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog R7 actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int wc;
        rst_n = 0; cap_en = 0; width_sel = 0; mode_sel = 0;
        smp_valid = 0; smp_stat = 0; smp_pkt = 0; smp_sync = 0; smp_trig = 0;
        tick(3);
        rst_n = 1;
        tick();
        chk("R1 word_valid", word_valid == 0, word_valid, 0);
        chk("R1 drain_empty", drain_empty == 1, drain_empty, 1);
        chk("R1 cfg_err", cfg_err == 0, cfg_err, 0);

        // R2 / R5: three 4-bit samples, the last a trigger
        start(0, 0);
        smp(1, 'h2, 0, 0); smp(3, 'hF, 1, 0); smp(5, 'h0, 0, 1);
        tick();
        chk("R2 layout", last_word == 32'h002FFB11, last_word, 32'h002FFB11);
        chk("R5 trigger slot", last_word[23:16] == 8'h2F, last_word[23:16], 8'h2F);
        stop();

        // R3 / R6: 8-bit demultiplexed, packet bits above width dropped
        start(1, 1);
        smp(4, 'h1AB, 0, 0); smp(0, 'h12, 1, 0);
        tick();
        chk("R3 R6 layout", last_word == 32'h0089055C, last_word, 32'h0089055C);
        stop();

        // R4 / R6 / R12: 16-bit with idle gaps carrying garbage
        start(2, 0);
        wc = word_cnt;
        smp(2, 'hFFFF, 1, 0);
        tick();
        chk("R6 upper zero", last_word == 32'h000FFFFA, last_word, 32'h000FFFFA);
        gap(4);
        smp(6, 'h1234, 0, 1);
        tick();
        chk("R4 trigger word", last_word == 32'h000091B7, last_word, 32'h000091B7);
        chk("R12 word count", word_cnt - wc == 2, word_cnt - wc, 2);
        stop();

        // R8: flush of a partial 4-bit word
        start(0, 0);
        smp(6, 9, 1, 0); smp(2, 1, 0, 0);
        cap_en = 0;
        tick();
        chk("R8 draining", drain_empty == 0, drain_empty, 0);
        tick(2);
        chk("R8 flushed word", last_word == 32'h00000ACE, last_word, 32'h00000ACE);
        chk("R8 drain done", drain_empty == 1, drain_empty, 1);

        // R9: enable and disable without samples
        wc = word_cnt;
        start(0, 0);
        tick();
        cap_en = 0;
        tick(2);
        chk("R9 no word", word_cnt == wc, word_cnt, wc);
        chk("R9 drain_empty", drain_empty == 1, drain_empty, 1);

        // R10: refused configurations
        wc = word_cnt;
        start(0, 1);
        chk("R10 demux 4-bit", cfg_err == 1, cfg_err, 1);
        smp(1, 1, 0, 0); smp(1, 1, 0, 0); smp(1, 1, 0, 0);
        tick();
        chk("R10 no words", word_cnt == wc, word_cnt, wc);
        stop();
        chk("R10 cleared", cfg_err == 0, cfg_err, 0);
        start(1, 2);
        chk("R10 mux mode", cfg_err == 1, cfg_err, 1);
        stop();
        start(3, 0);
        chk("R10 bad width", cfg_err == 1, cfg_err, 1);
        stop();

        // R11 / R7: settings change mid-capture
        start(0, 0);
        width_sel = 2'b10; mode_sel = 2'b10;
        wc = word_cnt;
        smp(1, 1, 0, 0); smp(1, 1, 0, 0);
        tick();
        chk("R7 no early word", word_cnt == wc, word_cnt, wc);
        smp(1, 1, 0, 0);
        tick();
        chk("R7 one word", word_cnt == wc + 1, word_cnt, wc + 1);
        chk("R11 latched width", last_word == 32'h00090909, last_word, 32'h00090909);
        stop();

        // R12: sample on the start edge is not packed; then mixed streams
        for (int w = 0; w < 3; w++) begin
            width_sel = 2'(w); mode_sel = (w == 1) ? 2'b01 : 2'b00;
            cap_en = 1; smp_valid = 1; smp_stat = 3'd3; smp_pkt = 16'h0F0F;
            tick();
            for (int k = 0; k < 40; k++) begin
                smp_valid = 1'($urandom);
                smp_stat  = 3'($urandom);
                smp_pkt   = 16'($urandom);
                smp_sync  = 1'($urandom);
                smp_trig  = ($urandom % 5) == 0;
                tick();
            end
            smp_valid = 0;
            stop();
        end

        summary();
        $finish;
    end

endmodule